// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration image into a programmable logic device over a passive serial link. It drives the device's configuration reset line, the serial clock and the serial data line. It watches the two status lines that the device returns: a status-ok line, which reads low on an error, and a configuration-complete line. Image bytes come from an upstream source over a valid/ready byte port. A start pulse launches the load, and the total byte count is captured at that moment.

Each attempt begins with a reset pulse to the device. The block then shifts every byte out serially and checks the status-ok line at fixed points in the stream. After the last byte it checks the configuration-complete line, and then it runs a fixed number of initialization clocks before a final status check. A failed attempt is retried from the reset pulse, up to a bounded number of tries. On each retry the block pulses a rewind strobe so that the byte source starts again from byte zero. The run ends with a sticky done or error flag.

Top module: `serial_cfg_master`

## Requirements
- R1: After reset, `cfgResetN` is 1 and `serClk`, `serData`, `busy`, `done`, `error`, `byteReady` and `rewind` are all 0.
- R2: Each attempt holds `cfgResetN` low for exactly SETTLE_CYCLES clock cycles. It then holds it high for exactly SETTLE_CYCLES cycles before `byteReady` first rises.
- R3: Each byte is sent bit 0 first, one bit per `serClk` period. `serData` changes only while `serClk` is low and is stable on each rising edge. Every low phase of `serClk` lasts exactly CLK_DIV clock cycles.
- R4: The status-ok line is sampled WAIT_CYCLES cycles after the byte with index k is sent, for every k with k mod CHECK_INTERVAL = 0, and also for the last byte. A low sample aborts the attempt at that point.
- R5: After the last byte, a low configuration-complete input makes the attempt fail.
- R6: A failed attempt starts again from the reset pulse and asserts `rewind` for one cycle, as long as fewer than MAX_TRIES attempts have been made. When the attempt that fails is the MAX_TRIES-th, `error` is set.
- R7: Once the configuration-complete line is seen high, exactly INIT_CLOCKS extra rising edges of `serClk` are driven. After that, both status inputs must be high, or `error` is set at once with no retry.
- R8: On success, `done` is set and `serClk` and `serData` are both driven high.
- R9: `done` and `error` are never both high, and each stays set until the next `start`. `busy` goes high in the cycle after an accepted `start` and stays high until one of the two flags is set.
- R10: `byteReady` is high only while the block waits for a byte. It is low during the reset pulse, while a byte is shifting, and while status is being checked. A byte is taken in a cycle where `byteValid` and `byteReady` are both high.
- R11: A byte count of zero sends no data and goes straight from the reset pulse to the configuration-complete check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; accepted when not busy |
| byteCount | input | CNT_W | Total image bytes, captured at start |
| byteData | input | 8 | Image byte from the source |
| byteValid | input | 1 | Source has a byte |
| byteReady | output | 1 | Block accepts a byte |
| rewind | output | 1 | One-cycle pulse: source restarts at byte zero |
| cfgResetN | output | 1 | Device configuration reset, active low |
| serClk | output | 1 | Serial configuration clock |
| serData | output | 1 | Serial configuration data |
| tgtStatusOk | input | 1 | Device status line, low means error |
| tgtCfgDone | input | 1 | Device configuration-complete line |
| busy | output | 1 | Load in progress |
| done | output | 1 | Sticky success flag |
| error | output | 1 | Sticky failure flag |

## Verification
The bench models the target device: it captures `serData` on every rising `serClk` edge and rebuilds the bytes. It is run with short images of 0, 1, 5, 6, 10 and 12 bytes. Status faults are placed before the first byte, in the middle of a check interval, just past an interval boundary and on the last byte. Together these tell the periodic checkpoints apart from the last-byte checkpoint, because the attempt must stop at exactly the predicted byte. Faults on the configuration-complete line that clear before the try limit, or never clear, separate a successful retry from exhaustion of the tries. A fault that appears only after the initialization clocks shows that the final check gives up at once without retrying.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef struct packed {
    logic loadByte;
    logic loadInit;
    logic parkHigh;
  } dpCmd_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_LO,
    ST_RST_HI,
    ST_FETCH,
    ST_SHIFT,
    ST_WAITCHK,
    ST_CHKDONE,
    ST_INITCLK,
    ST_DONE,
    ST_ERR
  } ctrlState_t;

endpackage

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter
  import ps_cfg_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int INIT_CLOCKS = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic [7:0] byteIn,
  output logic       serClk,
  output logic       serData,
  output logic       dpBusy
);
  localparam int DIV_W   = $clog2(CLK_DIV + 1);
  localparam int PULSE_N = (INIT_CLOCKS > 8) ? INIT_CLOCKS : 8;
  localparam int PULSE_W = $clog2(PULSE_N + 1);

  logic [DIV_W-1:0]   divCnt;
  logic [PULSE_W-1:0] bitsLeft;
  logic [7:0]         shReg;
  logic               initMode;

  assign dpBusy = (bitsLeft != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      bitsLeft <= '0;
      shReg    <= '0;
      initMode <= 1'b0;
      serClk   <= 1'b0;
      serData  <= 1'b0;
    end else if (cmd.loadByte) begin
      serClk   <= 1'b0;
      serData  <= byteIn[0];
      shReg    <= {1'b0, byteIn[7:1]};
      bitsLeft <= PULSE_W'(8);
      divCnt   <= '0;
      initMode <= 1'b0;
    end else if (cmd.loadInit) begin
      serClk   <= 1'b0;
      bitsLeft <= PULSE_W'(INIT_CLOCKS);
      divCnt   <= '0;
      initMode <= 1'b1;
    end else if (cmd.parkHigh) begin
      serClk  <= 1'b1;
      serData <= 1'b1;
    end else if (bitsLeft != '0) begin
      if (divCnt == DIV_W'(CLK_DIV - 1)) begin
        divCnt <= '0;
        if (!serClk) begin
          serClk <= 1'b1;
        end else begin
          bitsLeft <= bitsLeft - 1'b1;
          if (bitsLeft != PULSE_W'(1)) begin
            serClk <= 1'b0;
            if (!initMode) begin
              serData <= shReg[0];
              shReg   <= {1'b0, shReg[7:1]};
            end
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assert_data_stable_on_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serClk) |-> $stable(serData));

  assert_load_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadByte |-> !dpBusy);

endmodule

// File: rtl/ps_cfg_ctrl.sv
module ps_cfg_ctrl
  import ps_cfg_pkg::*;
#(
  parameter int CNT_W          = 32,
  parameter int SETTLE_CYCLES  = 100,
  parameter int WAIT_CYCLES    = 1000,
  parameter int CHECK_INTERVAL = 10240,
  parameter int MAX_TRIES      = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             byteValid,
  output logic             byteReady,
  output logic             rewind,
  output logic             cfgResetN,
  input  logic             tgtStatusOk,
  input  logic             tgtCfgDone,
  input  logic             dpBusy,
  output dpCmd_t           cmd,
  output logic             busy,
  output logic             done,
  output logic             error
);
  localparam int TMR_MAX = (SETTLE_CYCLES > WAIT_CYCLES) ? SETTLE_CYCLES : WAIT_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int MOD_W   = $clog2(CHECK_INTERVAL + 1);
  localparam int TRY_W   = $clog2(MAX_TRIES + 1);

  ctrlState_t       state;
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] byteIdx;
  logic [MOD_W-1:0] modCnt;
  logic [TRY_W-1:0] triesUsed;

  logic idleLike, checkNow, isLast, lastTry, attemptFail, finalOk;

  assign idleLike    = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_ERR);
  assign isLast      = (byteIdx == cntQ - CNT_W'(1));
  assign checkNow    = (modCnt == '0) || isLast;
  assign lastTry     = (triesUsed == TRY_W'(MAX_TRIES - 1));
  assign finalOk     = tgtStatusOk && tgtCfgDone;
  assign attemptFail = ((state == ST_WAITCHK) && (tmr == '0) && !tgtStatusOk) ||
                       ((state == ST_CHKDONE) && !tgtCfgDone);

  always_comb begin
    byteReady    = (state == ST_FETCH);
    rewind       = attemptFail && !lastTry;
    cmd.loadByte = (state == ST_FETCH) && byteValid;
    cmd.loadInit = (state == ST_CHKDONE) && tgtCfgDone;
    cmd.parkHigh = (state == ST_INITCLK) && !dpBusy && finalOk;
    cfgResetN    = (state != ST_RST_LO);
    busy         = !idleLike;
    done         = (state == ST_DONE);
    error        = (state == ST_ERR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tmr       <= '0;
      cntQ      <= '0;
      byteIdx   <= '0;
      modCnt    <= '0;
      triesUsed <= '0;
    end else if (attemptFail) begin
      if (lastTry) begin
        state <= ST_ERR;
      end else begin
        triesUsed <= triesUsed + 1'b1;
        state     <= ST_RST_LO;
        tmr       <= TMR_W'(SETTLE_CYCLES - 1);
      end
    end else begin
      case (state)
        ST_IDLE, ST_DONE, ST_ERR: if (start) begin
          state     <= ST_RST_LO;
          tmr       <= TMR_W'(SETTLE_CYCLES - 1);
          triesUsed <= '0;
          cntQ      <= byteCount;
        end
        ST_RST_LO: if (tmr == '0) begin
          state <= ST_RST_HI;
          tmr   <= TMR_W'(SETTLE_CYCLES - 1);
        end else tmr <= tmr - 1'b1;
        ST_RST_HI: if (tmr == '0) begin
          byteIdx <= '0;
          modCnt  <= '0;
          state   <= (cntQ == '0) ? ST_CHKDONE : ST_FETCH;
        end else tmr <= tmr - 1'b1;
        ST_FETCH: if (byteValid) state <= ST_SHIFT;
        ST_SHIFT: if (!dpBusy) begin
          if (checkNow) begin
            state <= ST_WAITCHK;
            tmr   <= TMR_W'(WAIT_CYCLES - 1);
          end else begin
            byteIdx <= byteIdx + 1'b1;
            modCnt  <= (modCnt == MOD_W'(CHECK_INTERVAL - 1)) ? '0 : modCnt + 1'b1;
            state   <= ST_FETCH;
          end
        end
        ST_WAITCHK: if (tmr != '0) begin
          tmr <= tmr - 1'b1;
        end else if (isLast) begin
          state <= ST_CHKDONE;
        end else begin
          byteIdx <= byteIdx + 1'b1;
          modCnt  <= (modCnt == MOD_W'(CHECK_INTERVAL - 1)) ? '0 : modCnt + 1'b1;
          state   <= ST_FETCH;
        end
        ST_CHKDONE: state <= ST_INITCLK;
        ST_INITCLK: if (!dpBusy) state <= finalOk ? ST_DONE : ST_ERR;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_ready_dp_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> !dpBusy);

  assert_rewind_then_reset_R6: assert property (@(posedge clk) disable iff (!rstN)
    rewind |=> !cfgResetN);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error) && !(busy && (done || error)));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (error && !start) |=> error);

endmodule

// File: rtl/serial_cfg_master.sv
module serial_cfg_master
  import ps_cfg_pkg::*;
#(
  parameter int CNT_W          = 32,
  parameter int CLK_DIV        = 4,
  parameter int SETTLE_CYCLES  = 100,
  parameter int WAIT_CYCLES    = 1000,
  parameter int CHECK_INTERVAL = 10240,
  parameter int MAX_TRIES      = 5,
  parameter int INIT_CLOCKS    = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [7:0]       byteData,
  input  logic             byteValid,
  output logic             byteReady,
  output logic             rewind,
  output logic             cfgResetN,
  output logic             serClk,
  output logic             serData,
  input  logic             tgtStatusOk,
  input  logic             tgtCfgDone,
  output logic             busy,
  output logic             done,
  output logic             error
);
  dpCmd_t cmd;
  logic   dpBusy;

  ps_cfg_ctrl #(
    .CNT_W(CNT_W), .SETTLE_CYCLES(SETTLE_CYCLES), .WAIT_CYCLES(WAIT_CYCLES),
    .CHECK_INTERVAL(CHECK_INTERVAL), .MAX_TRIES(MAX_TRIES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .byteValid(byteValid), .byteReady(byteReady), .rewind(rewind),
    .cfgResetN(cfgResetN), .tgtStatusOk(tgtStatusOk), .tgtCfgDone(tgtCfgDone),
    .dpBusy(dpBusy), .cmd(cmd), .busy(busy), .done(done), .error(error)
  );

  ps_cfg_shifter #(.CLK_DIV(CLK_DIV), .INIT_CLOCKS(INIT_CLOCKS)) u_shift (
    .clk(clk), .rstN(rstN), .cmd(cmd), .byteIn(byteData),
    .serClk(serClk), .serData(serData), .dpBusy(dpBusy)
  );

  assert_park_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (serClk && serData));

endmodule

// File: tb/serial_cfg_master_bench.sv
module serial_cfg_master_bench;
  localparam int CNT_W = 16, CLK_DIV = 2, SETTLE = 4, WAITC = 3;
  localparam int INTV = 4, TRIES = 3, INITC = 5;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [CNT_W-1:0] byteCount = '0;
  logic [7:0] byteData;
  logic byteValid, byteReady, rewind, cfgResetN, serClk, serData;
  logic tgtStatusOk, tgtCfgDone, busy, done, error;

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;

  serial_cfg_master #(
    .CNT_W(CNT_W), .CLK_DIV(CLK_DIV), .SETTLE_CYCLES(SETTLE), .WAIT_CYCLES(WAITC),
    .CHECK_INTERVAL(INTV), .MAX_TRIES(TRIES), .INIT_CLOCKS(INITC)
  ) u_serial_cfg_master (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .byteData(byteData), .byteValid(byteValid), .byteReady(byteReady),
    .rewind(rewind), .cfgResetN(cfgResetN), .serClk(serClk), .serData(serData),
    .tgtStatusOk(tgtStatusOk), .tgtCfgDone(tgtCfgDone),
    .busy(busy), .done(done), .error(error)
  );

  function automatic logic [7:0] srcByte(int i);
    return 8'((i * 37 + 11) ^ (i >> 2));
  endfunction

  // byte source
  int srcIdx = 0, curN = 0;
  assign byteValid = (srcIdx < curN);
  assign byteData  = srcByte(srcIdx);
  always @(posedge clk) begin
    if (rewind) srcIdx <= 0;
    else if (byteValid && byteReady) srcIdx <= srcIdx + 1;
  end

  // target device model
  int attempt = 0, bytesRx = 0, bitCnt = 0, extra = 0, dataErr = 0;
  int attBytes[8];
  logic [7:0] sh = '0;
  int statusFailN = 0, failByte = 1000, doneFailN = 0;
  bit finalFail = 0;
  always @(posedge serClk or negedge cfgResetN) begin
    if (!cfgResetN) begin
      attempt = attempt + 1; bitCnt = 0; bytesRx = 0; extra = 0;
    end else if (bytesRx < curN) begin
      sh = {serData, sh[7:1]};
      bitCnt = bitCnt + 1;
      if (bitCnt == 8) begin
        if (sh != srcByte(bytesRx)) dataErr = dataErr + 1;
        bytesRx = bytesRx + 1; bitCnt = 0;
        if (attempt < 8) attBytes[attempt] = bytesRx;
      end
    end else extra = extra + 1;
  end
  assign tgtCfgDone  = (attempt > doneFailN) && (bytesRx == curN);
  assign tgtStatusOk = !((attempt <= statusFailN) && (bytesRx >= failByte)) &&
                       !(finalFail && extra >= INITC);

  // monitors
  int rLow = 0, lowErr = 0, hiCnt = 0, hiErr = 0, clkLow = 0, clkErr = 0;
  int readyErr = 0, rewCnt = 0;
  bit armHi = 0, inRun = 0, prevClk = 0;
  always @(negedge clk) begin
    if (!cfgResetN) begin rLow++; armHi = 1; hiCnt = 0; end
    else begin
      if (rLow != 0) begin if (rLow != SETTLE) lowErr++; rLow = 0; end
      if (armHi) begin
        if (byteReady) begin if (hiCnt != SETTLE) hiErr++; armHi = 0; end
        else hiCnt++;
      end
    end
    if (prevClk && !serClk) begin inRun = 1; clkLow = 0; end
    if (!serClk && inRun) clkLow++;
    if (serClk && inRun) begin if (clkLow != CLK_DIV) clkErr++; inRun = 0; end
    prevClk = serClk;
    if (byteReady && !cfgResetN) readyErr++;
    if (rewind) rewCnt++;
  end

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runTest(int n, int sfN, int fb, int dfN, bit ff,
                         bit expDone, int expAtt, int expFirst);
    @(negedge clk);
    curN = n; byteCount = CNT_W'(n); statusFailN = sfN; failByte = fb;
    doneFailN = dfN; finalFail = ff; srcIdx = 0; attempt = 0; bytesRx = 0;
    bitCnt = 0; extra = 0; dataErr = 0; rewCnt = 0; lowErr = 0; hiErr = 0;
    clkErr = 0; readyErr = 0;
    foreach (attBytes[i]) attBytes[i] = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done && !error, "R9 busy after start", int'(busy), 1);
    check(!cfgResetN, "R2 reset pulse begins", int'(cfgResetN), 0);
    for (int k = 0; k < 20000 && !(done || error); k++) @(negedge clk);
    check(done == expDone && error == !expDone, "R6 R9 outcome", int'(done), int'(expDone));
    check(attempt == expAtt, "R6 attempt count", attempt, expAtt);
    check(rewCnt == expAtt - 1, "R6 rewind pulses", rewCnt, expAtt - 1);
    check(dataErr == 0, "R3 captured bytes", dataErr, 0);
    check(clkErr == 0, "R3 low phase length", clkErr, 0);
    check(lowErr == 0 && hiErr == 0, "R2 settle timing", lowErr + hiErr, 0);
    check(readyErr == 0, "R10 ready during reset", readyErr, 0);
    if (expFirst >= 0) check(attBytes[1] == expFirst, "R4 abort point", attBytes[1], expFirst);
    if (expDone) begin
      check(extra == INITC, "R7 init clocks", extra, INITC);
      check(serClk && serData, "R8 park high", int'({serClk, serData}), 3);
      check(srcIdx == n, "R10 bytes taken", srcIdx, n);
      check(bytesRx == n, "R5 last attempt length", bytesRx, n);
    end
    check(!busy, "R9 busy cleared", int'(busy), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cfgResetN && !serClk && !serData && !busy && !done && !error && !byteReady && !rewind,
          "R1 reset state", int'({cfgResetN, serClk, serData, busy, done, error, byteReady}), 64);
    rstN = 1'b1;
    @(negedge clk);
    runTest(10, 0, 1000, 0, 0, 1, 1, 10);   // clean image
    repeat (40) @(negedge clk);
    check(done && !error, "R9 done sticky", int'(done), 1);
    runTest(1, 0, 1000, 0, 0, 1, 1, 1);     // single byte
    runTest(0, 0, 1000, 0, 0, 1, 1, 0);     // R11 empty image
    runTest(10, 1, 3, 0, 0, 1, 2, 5);       // R4 fault mid interval, caught at index 4
    runTest(12, 1, 9, 0, 0, 1, 2, 9);       // R4 caught at index 8
    runTest(12, 1, 12, 0, 0, 1, 2, 12);     // R4 caught on last byte
    runTest(10, 1, 1, 0, 0, 1, 2, 1);       // R4 caught at index 0
    runTest(6, 0, 1000, 2, 0, 1, 3, 6);     // R5 complete line late, retry succeeds
    runTest(6, 0, 1000, 3, 0, 0, 3, 6);     // R5 R6 tries exhausted
    repeat (40) @(negedge clk);
    check(error && !done, "R9 error sticky", int'(error), 1);
    runTest(10, 3, 2, 0, 0, 0, 3, 5);       // R6 status fails every try
    runTest(5, 0, 1000, 0, 1, 0, 1, 5);     // R7 final check fails, no retry
    check(extra == INITC, "R7 init clocks before final check", extra, INITC);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule